// File: doc/BRIEF.md
# Dedicated-Slot Partial-Result Buffer Manager

This block provides the bookkeeping for the three waiting stores of a pipelined reduction engine. The stores are operand-1 waiters, operand-2 waiters and parked final elements of a set. Every tree node of every iteration that can be in flight owns one private slot in each store. The slot address is therefore a fixed function of the iteration window and the node index, and no search or free list is needed. The scheduler issues a write request when a value has to wait and a read request when the node that owns the value fires. The block turns each request into a registered one-hot RAM enable and a slot address. It also keeps one occupancy bit per slot, which is set on write and cleared on read.

The adder pipeline depth `PIPE_STAGES` (P, at least 2) sets the geometry:
- `WINDOWS` = ceil(log2 P) + 2 iteration windows.
- `NODES` = ceil(P/2) storing nodes per iteration.
- `SLOTS` = `WINDOWS`·`NODES` entries per store.

Slot `s` of a window is reused by the iteration `WINDOWS` iterations later. The data RAMs and their companion path-record RAMs sit outside this block and share its enables and addresses.

Top module: `partial_slot_mgr`

## Requirements
- R1: A request for window `w` and node `n` maps to slot address `w*NODES + n`. The same mapping is used for reads and writes, and the address appears on `ram_waddr` / `ram_raddr` one cycle after the request edge.
- R2: A write request with store code 0 (operand 1), 1 (operand 2) or 2 (parked element) raises bit [code] of `ram_we` for exactly the one cycle after the request edge. A write with code 3 raises no bit and changes no occupancy.
- R3: A read request raises bit [code] of `ram_re` for exactly one cycle after the request edge, using the same codes as R2. A read with code 3 raises no bit and reports no hit.
- R4: A write sets the occupancy bit at index `code*SLOTS + slot`, and the bit is visible on `occupancy` one cycle after the request edge.
- R5: A read reports, on `rd_hit` in the following cycle, whether the slot was occupied before the read. The read then clears that occupancy bit.
- R6: A write to a slot whose occupancy bit is set, and which is not read in the same cycle, raises `wr_clash` for one cycle. The write is still performed.
- R7: A read and a write of the same slot in the same cycle behave as follows: the read sees the old occupancy (hit), the slot stays occupied afterwards, and no clash is flagged.
- R8: The three stores are independent. A slot occupied in one store does not affect a request for the same address in another store.
- R9: Synchronous active-high reset clears all occupancy bits, enables, `rd_hit` and `wr_clash`.
- R10: With P=4 the geometry is 4 windows by 2 nodes. The highest slot (window 3, node 1) has address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request |
| wr_store | input | 2 | Store code for the write (0 op1, 1 op2, 2 parked, 3 none) |
| wr_win | input | WIN_W | Iteration window of the writing node |
| wr_node | input | NODE_W | Node index of the writing node |
| rd_req | input | 1 | Read request |
| rd_store | input | 2 | Store code for the read |
| rd_win | input | WIN_W | Iteration window of the firing node |
| rd_node | input | NODE_W | Node index of the firing node |
| ram_we | output | 3 | One-hot write enable per store (data and record RAM) |
| ram_waddr | output | AW | Write slot address |
| ram_re | output | 3 | One-hot read enable per store |
| ram_raddr | output | AW | Read slot address |
| rd_hit | output | 1 | The slot that was read held a valid entry |
| wr_clash | output | 1 | A write landed on a still-occupied slot |
| occupancy | output | 3·SLOTS | Occupancy bits, index store*SLOTS+slot |

## Verification
A wrong slot mapping shows one cycle after the request as an unexpected `ram_waddr` or `ram_raddr`. It also shows as an occupancy bit set at the wrong index. A valid bit that is not cleared, or is cleared too early, shows on the next read of that slot as a wrong `rd_hit`. It also shows on the next write as a spurious or missing `wr_clash`, normally within a few cycles. Crosstalk between stores, and a wrong ordering of a read and a write to the same slot in one cycle, show on the `occupancy` vector in the cycle after the edge.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int NSTORE = 3;

  typedef enum logic [1:0] {
    STORE_OP1  = 2'd0,
    STORE_OP2  = 2'd1,
    STORE_PARK = 2'd2,
    STORE_NONE = 2'd3
  } store_e;

  function automatic int windows_for(input int pipe);
    return $clog2(pipe) + 2;
  endfunction

  function automatic int nodes_for(input int pipe);
    return (pipe + 1) / 2;
  endfunction
endpackage

// File: rtl/rbm_slot_map.sv
module rbm_slot_map import rbm_pkg::*; #(
  parameter int WINDOWS = 4,
  parameter int NODES   = 2,
  parameter int WIN_W   = 2,
  parameter int NODE_W  = 1,
  parameter int AW      = 3
) (
  input  logic              req,
  input  logic [1:0]        store,
  input  logic [WIN_W-1:0]  win,
  input  logic [NODE_W-1:0] node,
  output logic [NSTORE-1:0] en,
  output logic [AW-1:0]     slot
);
  logic in_range;
  int unsigned lin;

  always_comb begin
    in_range = (int'(win) < WINDOWS) && (int'(node) < NODES);
    lin      = int'(win) * NODES + int'(node);
    slot     = lin[AW-1:0];
  end

  for (genvar s = 0; s < NSTORE; s++) begin : g_dec
    assign en[s] = req && in_range && (store_e'(store) == store_e'(s));
  end
endmodule

// File: rtl/rbm_valid_bank.sv
module rbm_valid_bank #(
  parameter int SLOTS = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_slot,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_slot,
  output logic [SLOTS-1:0] valid,
  output logic             rd_old,
  output logic             clash
);
  logic same_slot;

  always_comb begin
    same_slot = rd_en && (rd_slot == wr_slot);
    rd_old    = rd_en && valid[rd_slot];
    clash     = wr_en && valid[wr_slot] && !same_slot;
  end

  // read clears first, write sets last: a same-cycle reuse keeps the slot
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
    end else begin
      if (rd_en) valid[rd_slot] <= 1'b0;
      if (wr_en) valid[wr_slot] <= 1'b1;
    end
  end

  assert_write_sets_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid[$past(wr_slot)]);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(wr_en && wr_slot == rd_slot)) |=> !valid[$past(rd_slot)]);
endmodule

// File: rtl/partial_slot_mgr.sv
module partial_slot_mgr import rbm_pkg::*; #(
  parameter  int PIPE_STAGES = 4,
  localparam int WINDOWS = windows_for(PIPE_STAGES),
  localparam int NODES   = nodes_for(PIPE_STAGES),
  localparam int SLOTS   = WINDOWS * NODES,
  localparam int WIN_W   = $clog2(WINDOWS),
  localparam int NODE_W  = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_req,
  input  logic [1:0]              wr_store,
  input  logic [WIN_W-1:0]        wr_win,
  input  logic [NODE_W-1:0]       wr_node,
  input  logic                    rd_req,
  input  logic [1:0]              rd_store,
  input  logic [WIN_W-1:0]        rd_win,
  input  logic [NODE_W-1:0]       rd_node,
  output logic [NSTORE-1:0]       ram_we,
  output logic [AW-1:0]           ram_waddr,
  output logic [NSTORE-1:0]       ram_re,
  output logic [AW-1:0]           ram_raddr,
  output logic                    rd_hit,
  output logic                    wr_clash,
  output logic [NSTORE*SLOTS-1:0] occupancy
);
  logic [NSTORE-1:0] wr_en, rd_en, old_hit, clash_v;
  logic [AW-1:0]     wr_slot, rd_slot;

  rbm_slot_map #(.WINDOWS(WINDOWS), .NODES(NODES), .WIN_W(WIN_W),
                 .NODE_W(NODE_W), .AW(AW)) u_wmap (
    .req(wr_req), .store(wr_store), .win(wr_win), .node(wr_node),
    .en(wr_en), .slot(wr_slot));

  rbm_slot_map #(.WINDOWS(WINDOWS), .NODES(NODES), .WIN_W(WIN_W),
                 .NODE_W(NODE_W), .AW(AW)) u_rmap (
    .req(rd_req), .store(rd_store), .win(rd_win), .node(rd_node),
    .en(rd_en), .slot(rd_slot));

  for (genvar s = 0; s < NSTORE; s++) begin : g_bank
    rbm_valid_bank #(.SLOTS(SLOTS), .AW(AW)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(wr_en[s]), .wr_slot(wr_slot),
      .rd_en(rd_en[s]), .rd_slot(rd_slot),
      .valid(occupancy[s*SLOTS +: SLOTS]),
      .rd_old(old_hit[s]), .clash(clash_v[s]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we    <= '0;
      ram_re    <= '0;
      ram_waddr <= '0;
      ram_raddr <= '0;
      rd_hit    <= 1'b0;
      wr_clash  <= 1'b0;
    end else begin
      ram_we   <= wr_en;
      ram_re   <= rd_en;
      rd_hit   <= |old_hit;
      wr_clash <= |clash_v;
      if (|wr_en) ram_waddr <= wr_slot;
      if (|rd_en) ram_raddr <= rd_slot;
    end
  end

  assert_we_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ram_we));

  assert_re_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ram_re));

  assert_addr_range_R1: assert property (@(posedge clk) disable iff (rst)
    (|ram_we) |-> (int'(ram_waddr) < SLOTS));

  assert_hit_needs_read_R5: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> (|ram_re));

  assert_clash_needs_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_clash |-> (|ram_we));
endmodule

// File: tb/tb_partial_slot_mgr.sv
module tb_partial_slot_mgr;
  logic clk = 1'b0;
  logic rst;
  logic wr_req, rd_req;
  logic [1:0] wr_store, rd_store, wr_win, rd_win;
  logic wr_node, rd_node;
  logic [2:0] ram_we, ram_re, ram_waddr, ram_raddr;
  logic rd_hit, wr_clash;
  logic [23:0] occupancy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  partial_slot_mgr #(.PIPE_STAGES(4)) dut (
    .clk(clk), .rst(rst),
    .wr_req(wr_req), .wr_store(wr_store), .wr_win(wr_win), .wr_node(wr_node),
    .rd_req(rd_req), .rd_store(rd_store), .rd_win(rd_win), .rd_node(rd_node),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_re(ram_re),
    .ram_raddr(ram_raddr), .rd_hit(rd_hit), .wr_clash(wr_clash),
    .occupancy(occupancy));

  typedef struct packed {
    logic w; logic [1:0] ws; logic [1:0] ww; logic wn;
    logic r; logic [1:0] rs; logic [1:0] rw; logic rn;
    logic [2:0] e_we; logic [2:0] e_wa; logic [2:0] e_re; logic [2:0] e_ra;
    logic e_hit; logic e_clash; logic [23:0] e_occ;
  } vec_t;

  localparam int NV = 12;
  // occupancy index = store*8 + window*2 + node
  localparam vec_t VEC [NV] = '{
    '{1'b1,2'd0,2'd1,1'b1, 1'b0,2'd0,2'd0,1'b0, 3'b001,3'd3,3'b000,3'd0, 1'b0,1'b0, 24'h000008},
    '{1'b1,2'd1,2'd2,1'b0, 1'b1,2'd0,2'd1,1'b1, 3'b010,3'd4,3'b001,3'd3, 1'b1,1'b0, 24'h001000},
    '{1'b0,2'd0,2'd0,1'b0, 1'b1,2'd0,2'd1,1'b1, 3'b000,3'd0,3'b001,3'd3, 1'b0,1'b0, 24'h001000},
    '{1'b1,2'd2,2'd3,1'b1, 1'b0,2'd0,2'd0,1'b0, 3'b100,3'd7,3'b000,3'd0, 1'b0,1'b0, 24'h801000},
    '{1'b1,2'd2,2'd3,1'b1, 1'b0,2'd0,2'd0,1'b0, 3'b100,3'd7,3'b000,3'd0, 1'b0,1'b1, 24'h801000},
    '{1'b1,2'd2,2'd3,1'b1, 1'b1,2'd2,2'd3,1'b1, 3'b100,3'd7,3'b100,3'd7, 1'b1,1'b0, 24'h801000},
    '{1'b0,2'd0,2'd0,1'b0, 1'b1,2'd2,2'd3,1'b1, 3'b000,3'd0,3'b100,3'd7, 1'b1,1'b0, 24'h001000},
    '{1'b1,2'd3,2'd0,1'b0, 1'b1,2'd3,2'd0,1'b0, 3'b000,3'd0,3'b000,3'd0, 1'b0,1'b0, 24'h001000},
    '{1'b0,2'd0,2'd0,1'b0, 1'b1,2'd1,2'd2,1'b0, 3'b000,3'd0,3'b010,3'd4, 1'b1,1'b0, 24'h000000},
    '{1'b1,2'd0,2'd0,1'b0, 1'b1,2'd1,2'd0,1'b0, 3'b001,3'd0,3'b010,3'd0, 1'b0,1'b0, 24'h000001},
    '{1'b0,2'd0,2'd0,1'b0, 1'b1,2'd0,2'd0,1'b0, 3'b000,3'd0,3'b001,3'd0, 1'b1,1'b0, 24'h000000},
    '{1'b0,2'd0,2'd0,1'b0, 1'b0,2'd0,2'd0,1'b0, 3'b000,3'd0,3'b000,3'd0, 1'b0,1'b0, 24'h000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wr_req = 0; wr_store = 0; wr_win = 0; wr_node = 0;
    rd_req = 0; rd_store = 0; rd_win = 0; rd_node = 0;
  endtask

  // drive at negedge, sample 2 ns after the next posedge
  task automatic apply(input vec_t v);
    @(negedge clk);
    wr_req = v.w; wr_store = v.ws; wr_win = v.ww; wr_node = v.wn;
    rd_req = v.r; rd_store = v.rs; rd_win = v.rw; rd_node = v.rn;
    @(posedge clk); #2;
    idle_inputs();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    check("R9 occupancy after reset", 32'(occupancy), 0);
    check("R9 ram_we after reset", 32'(ram_we), 0);
    check("R9 ram_re after reset", 32'(ram_re), 0);
    check("R9 rd_hit after reset", 32'(rd_hit), 0);
    check("R9 wr_clash after reset", 32'(wr_clash), 0);
    @(negedge clk); rst = 1'b0;

    // table: row 6 covers R7, rows 8 and 10 cover R2/R3 code 3 and R8
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check("R2 ram_we", 32'(ram_we), 32'(VEC[i].e_we));
      if (VEC[i].e_we != 0) check("R1 ram_waddr", 32'(ram_waddr), 32'(VEC[i].e_wa));
      check("R3 ram_re", 32'(ram_re), 32'(VEC[i].e_re));
      if (VEC[i].e_re != 0) check("R1 ram_raddr", 32'(ram_raddr), 32'(VEC[i].e_ra));
      check("R5 rd_hit", 32'(rd_hit), 32'(VEC[i].e_hit));
      check("R6 wr_clash", 32'(wr_clash), 32'(VEC[i].e_clash));
      check("R4 occupancy", 32'(occupancy), 32'(VEC[i].e_occ));
    end

    // R10 / R1: fill every slot of the operand-2 store
    for (int w = 0; w < 4; w++) begin
      for (int n = 0; n < 2; n++) begin
        vec_t v;
        v = '0;
        v.w = 1'b1; v.ws = 2'd1; v.ww = 2'(w); v.wn = 1'(n);
        apply(v);
        check("R1 fill address", 32'(ram_waddr), 32'(w * 2 + n));
        check("R2 fill enable", 32'(ram_we), 32'b010);
      end
    end
    check("R10 top slot address", 32'(ram_waddr), 7);
    check("R4 full op2 store", 32'(occupancy), 32'h00FF00);

    // R9 mid-run reset clears occupancy
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    check("R9 occupancy after mid reset", 32'(occupancy), 0);
    @(negedge clk); rst = 1'b0;
    begin
      vec_t v;
      v = '0;
      v.r = 1'b1; v.rs = 2'd1; v.rw = 2'd2; v.rn = 1'b1;
      apply(v);
      check("R9 read after reset misses", 32'(rd_hit), 0);
      check("R3 read enable after reset", 32'(ram_re), 32'b010);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule